// File: doc/BRIEF.md
# Priority-less platform interrupt controller

This controller collects 32 level-sensitive interrupt lines and presents them to 32 targets, called contexts. Every line passes through its own gateway. The gateway records the line as pending and then blocks it, so a line held high raises at most one request until the handler reports that it is done. There is one pending vector, and all contexts share it. Each context has its own enable mask. Each context also has a notification output that is high whenever at least one source enabled for it is pending.

Software uses a word-addressed register bus. The read path is combinational. Side effects take place at the next rising clock edge. A context claims a source by reading its claim register, which returns the highest-numbered pending enabled source and consumes it. The context writes the same ID back to the same register to release the gateway. There is no priority arbitration. The per-source priority slots and the per-context threshold registers always read zero and ignore writes.

All addresses below are word addresses on `addr_i`. The byte offset is four times the word address.

Top module: `irq_router`

## Requirements
- R1: After reset, the pending vector, all gateway masks and all enable masks are zero, and every bit of `irq_o` is low.
- R2: At each rising edge, every active source whose gateway is open becomes pending, and its gateway closes. A source that stays high is not pended again after it is claimed, until it is completed.
- R3: `irq_o[n]` is high exactly when the pending vector AND the enable mask of context n is nonzero.
- R4: The enable mask of context n is at word 0x800 + n*0x20 (byte 0x2000 + n*0x80). It is readable and writable. Bit 0 is always stored as zero.
- R5: A read of word 0x400 (byte 0x1000) returns the pending vector, with bit k for source k. A write to that word is an error and changes nothing.
- R6: Words 1 to 31 complete without error, read as zero and have no effect.
- R7: The threshold register of context n is at word 0x80000 + n*0x400. It reads zero, and writes to it are ignored.
- R8: A read of word 0x80001 + n*0x400 returns, as a binary number, the index of the highest set bit of (pending AND the enable mask of context n). At the edge, that pending bit clears.
- R9: A claim read that finds no candidate returns 0 and changes no state.
- R10: A write of ID k to the claim word of context n opens gateway k only if k < 32 and bit k of that context's enable mask is set. Otherwise the write changes nothing. If source k is still high at that edge, it becomes pending again at the same edge.
- R11: `err_o` is high during any request to an address that is not defined above, including word 0, and also for a write to the pending word. `rdata_o` reads zero while `err_o` is high.
- R12: A claim read and a new source assertion in the same cycle both take effect. The clear applies to the old pending value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-sensitive interrupt source lines |
| req_i | input | 1 | Bus request, one access per cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 22 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, valid in the request cycle |
| err_o | output | 1 | Access error, combinational |
| irq_o | output | 32 | Notification output, one bit per context |

## Verification
Assertions check gateway behaviour on every cycle. A newly pending bit must come from an active source, and its gateway must close with it. A claimed bit must clear unless its source re-arms it. A valid completion must open the gateway. An error response must carry zero data. The bench's scenarios are needed for the rest: the address map, the forced zero in enable bit 0, the highest-index claim selection, a completion that the context's enable mask rejects, and the same-cycle collision of a claim with a new source. The bench compares all of these against a reference model that it builds from the requirements.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    K_NONE,
    K_PRIO,
    K_PEND,
    K_EN,
    K_THR,
    K_CLAIM
  } reg_kind_e;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] claim_clr_i,
  input  logic [NSRC-1:0] cmpl_clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q, mask_q, mask_eff;

  // completion opens the gate before this edge's sampling
  assign mask_eff = mask_q & ~cmpl_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & ~claim_clr_i) | (src_i & ~mask_eff);
      mask_q <= mask_eff | src_i;
    end
  end

  assign pend_o = pend_q;

  a_r2_pend_from_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~$past(pend_q) & ~$past(src_i)) == '0);
  a_r2_pend_closes_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~$past(pend_q) & ~mask_q) == '0);
  a_r8_claim_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & $past(claim_clr_i & ~src_i)) == '0);
  a_r10_cmpl_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q & $past(cmpl_clr_i & ~src_i)) == '0);
endmodule

// File: rtl/irq_decode.sv
module irq_decode
  import irq_pkg::*;
#(
  parameter int unsigned AW   = 22,
  parameter int unsigned NSRC = 32,
  parameter int unsigned NCTX = 32,
  parameter int unsigned CW   = $clog2(NCTX)
) (
  input  logic [AW-1:0] addr_i,
  output reg_kind_e     kind_o,
  output logic [CW-1:0] ctx_o
);
  localparam int unsigned EN_SH = 5;
  localparam int unsigned CL_SH = 10;
  localparam logic [AW-1:0] PEND_W  = AW'(32'h400);
  localparam logic [AW-1:0] EN_BASE = AW'(32'h800);
  localparam logic [AW-1:0] CL_BASE = AW'(32'h80000);
  localparam logic [AW-1:0] EN_SPAN = AW'(NCTX << EN_SH);
  localparam logic [AW-1:0] CL_SPAN = AW'(NCTX << CL_SH);

  logic [AW-1:0] en_off, cl_off;
  assign en_off = addr_i - EN_BASE;
  assign cl_off = addr_i - CL_BASE;

  always_comb begin
    kind_o = K_NONE;
    ctx_o  = '0;
    if (addr_i != '0 && addr_i < AW'(NSRC)) begin
      kind_o = K_PRIO;
    end else if (addr_i == PEND_W) begin
      kind_o = K_PEND;
    end else if (addr_i >= EN_BASE && en_off < EN_SPAN && en_off[EN_SH-1:0] == '0) begin
      kind_o = K_EN;
      ctx_o  = CW'(en_off >> EN_SH);
    end else if (addr_i >= CL_BASE && cl_off < CL_SPAN && cl_off[CL_SH-1:1] == '0) begin
      kind_o = cl_off[0] ? K_CLAIM : K_THR;
      ctx_o  = CW'(cl_off >> CL_SH);
    end
  end
endmodule

// File: rtl/irq_ctx_bank.sv
module irq_ctx_bank #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned NCTX = 32,
  parameter int unsigned CW   = $clog2(NCTX)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_we_i,
  input  logic [CW-1:0]   ctx_i,
  input  logic [NSRC-1:0] en_wdata_i,
  input  logic [NSRC-1:0] pend_i,
  output logic [NSRC-1:0] en_sel_o,
  output logic [NCTX-1:0] irq_o
);
  logic [NSRC-1:0] en_q [NCTX];

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[c] <= '0;
      end else if (en_we_i && ctx_i == CW'(c)) begin
        en_q[c] <= {en_wdata_i[NSRC-1:1], 1'b0}; // ID 0 means no interrupt
      end
    end
    assign irq_o[c] = |(pend_i & en_q[c]);
  end

  assign en_sel_o = en_q[ctx_i];
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  cand_i,
  output logic [IW-1:0] id_o,
  output logic          any_o
);
  always_comb begin
    id_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i]) id_o = IW'(i);
    end
  end
  assign any_o = |cand_i;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned NCTX = 32,
  parameter int unsigned AW   = 22,
  parameter int unsigned DW   = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            err_o,
  output logic [NCTX-1:0] irq_o
);
  localparam int unsigned CW = $clog2(NCTX);
  localparam int unsigned IW = $clog2(NSRC);

  reg_kind_e       kind;
  logic [CW-1:0]   ctx;
  logic [NSRC-1:0] pend, en_sel, cand, claim_clr, cmpl_clr;
  logic [IW-1:0]   pick_id, cmpl_id;
  logic            pick_any, rd, wr, cmpl_ok;

  assign rd = req_i & ~we_i;
  assign wr = req_i & we_i;

  irq_decode #(.AW(AW), .NSRC(NSRC), .NCTX(NCTX), .CW(CW)) u_dec (
    .addr_i(addr_i), .kind_o(kind), .ctx_o(ctx)
  );

  irq_gateway #(.NSRC(NSRC)) u_gw (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
    .claim_clr_i(claim_clr), .cmpl_clr_i(cmpl_clr), .pend_o(pend)
  );

  irq_ctx_bank #(.NSRC(NSRC), .NCTX(NCTX), .CW(CW)) u_ctx (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_we_i(wr && kind == K_EN),
    .ctx_i(ctx), .en_wdata_i(wdata_i[NSRC-1:0]), .pend_i(pend),
    .en_sel_o(en_sel), .irq_o(irq_o)
  );

  assign cand = pend & en_sel;

  irq_pick #(.N(NSRC), .IW(IW)) u_pick (
    .cand_i(cand), .id_o(pick_id), .any_o(pick_any)
  );

  assign claim_clr = (rd && kind == K_CLAIM && pick_any) ? (NSRC'(1) << pick_id) : '0;

  assign cmpl_id   = wdata_i[IW-1:0];
  assign cmpl_ok   = wr && kind == K_CLAIM && wdata_i < DW'(NSRC) && en_sel[cmpl_id];
  assign cmpl_clr  = cmpl_ok ? (NSRC'(1) << cmpl_id) : '0;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (kind)
        K_PEND:  rdata_o = DW'(pend);
        K_EN:    rdata_o = DW'(en_sel);
        K_CLAIM: rdata_o = DW'(pick_id) & {DW{pick_any}};
        default: rdata_o = '0;
      endcase
    end
  end

  assign err_o = req_i && (kind == K_NONE || (we_i && kind == K_PEND));

  a_r11_err_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0);
endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [21:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;
  logic [31:0] irq_o;

  always #2 clk = ~clk;

  irq_router u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o), .irq_o(irq_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_pend = '0, m_mask = '0;
  logic [31:0] m_en [32];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // kinds: 0 undefined, 1 priority, 2 pending, 3 enable, 4 threshold, 5 claim
  function automatic int kind_of(logic [21:0] a, output int c);
    int unsigned b = 32'(a) * 4;
    c = 0;
    if (b >= 4 && b < 128) return 1;
    if (b == 32'h1000) return 2;
    if (b >= 32'h2000 && b < 32'h3000 && b % 128 == 0) begin c = (b - 32'h2000) / 128; return 3; end
    if (b >= 32'h200000 && b < 32'h220000) begin
      c = (b - 32'h200000) / 4096;
      if (b % 4096 == 0) return 4;
      if (b % 4096 == 4) return 5;
    end
    return 0;
  endfunction

  function automatic int top_bit(logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  task automatic bus(bit req, bit we, logic [21:0] a, logic [31:0] wd, logic [31:0] src, string tag);
    int c, k;
    logic [31:0] exp_rd, clr, cmp, cand, meff;
    bit exp_err;
    @(negedge clk);
    req_i = req; we_i = we; addr_i = a; wdata_i = wd; src_i = src;
    #1;
    k = kind_of(a, c);
    exp_rd = '0; exp_err = 0; clr = '0; cmp = '0;
    cand = m_pend & m_en[c];
    if (req) begin
      exp_err = (k == 0) || (we && k == 2);
      if (!we) begin
        if (k == 2) exp_rd = m_pend;
        if (k == 3) exp_rd = m_en[c];
        if (k == 5 && cand != 0) begin exp_rd = 32'(top_bit(cand)); clr = 32'd1 << top_bit(cand); end
      end
    end
    chk({tag, " err"}, 32'(err_o), 32'(exp_err));
    if (req && !we) chk({tag, " rdata"}, rdata_o, exp_rd);
    @(posedge clk);
    if (req && we && k == 3) m_en[c] = wd & ~32'd1;
    if (req && we && k == 5 && wd < 32 && m_en[c][wd[4:0]]) cmp = 32'd1 << wd[4:0];
    meff = m_mask & ~cmp;
    m_pend = (m_pend & ~clr) | (src & ~meff);
    m_mask = meff | src;
    #1;
    begin
      logic [31:0] exp_irq;
      for (int n = 0; n < 32; n++) exp_irq[n] = |(m_pend & m_en[n]);
      chk("R3 irq", irq_o, exp_irq);
    end
  endtask

  function automatic logic [21:0] en_a(int n);  return 22'(32'h800 + n * 32'h20); endfunction
  function automatic logic [21:0] thr_a(int n); return 22'(32'h80000 + n * 32'h400); endfunction
  function automatic logic [21:0] cl_a(int n);  return 22'(32'h80001 + n * 32'h400); endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'h1234abcd));
    for (int n = 0; n < 32; n++) m_en[n] = '0;
    #1;
    chk("R1 irq in reset", irq_o, '0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    bus(1, 0, 22'h400, 0, 0, "R1 pend");
    bus(1, 0, en_a(7), 0, 0, "R1 en");
    // R4 map and forced bit 0
    bus(1, 1, en_a(0), 32'hffff_ffff, 0, "R4 wr0");
    bus(1, 0, en_a(0), 0, 0, "R4 rd0");
    bus(1, 1, en_a(1), 32'h0000_0041, 0, "R4 wr1");
    bus(1, 0, 22'h820, 0, 0, "R4 rd1");
    // R2 level capture, R3 per context
    bus(0, 0, 0, 0, 32'h0000_0020, "R2 src5");
    bus(1, 0, 22'h400, 0, 32'h0000_0020, "R5 pend");
    // R8 claim highest, R2 held source not re-pended
    bus(1, 0, cl_a(0), 0, 32'h0000_0020, "R8 claim");
    bus(1, 0, 22'h400, 0, 32'h0000_0020, "R2 held");
    bus(1, 0, cl_a(0), 0, 32'h0000_0020, "R9 empty");
    // R10 completion rejected by ctx1 (bit5 off), accepted by ctx0 with src held
    bus(1, 1, cl_a(1), 5, 32'h0000_0020, "R10 reject");
    bus(1, 0, 22'h400, 0, 32'h0000_0020, "R10 rejected");
    bus(1, 1, cl_a(0), 5, 32'h0000_0020, "R10 accept");
    bus(1, 0, 22'h400, 0, 0, "R10 repend");
    bus(1, 1, cl_a(0), 40, 0, "R10 id range");
    // R12 claim with new source in same cycle
    bus(0, 0, 0, 0, 32'h0000_0040, "R12 src6");
    bus(1, 0, cl_a(1), 0, 32'h8000_0000, "R12 claim6");
    bus(1, 0, 22'h400, 0, 0, "R12 pend");
    bus(1, 0, cl_a(0), 0, 0, "R8 highest");
    // R6, R7, R11
    bus(1, 1, 22'd3, 32'hffff_ffff, 0, "R6 wr");
    bus(1, 0, 22'd3, 0, 0, "R6 rd");
    bus(1, 1, thr_a(9), 32'h7, 0, "R7 wr");
    bus(1, 0, thr_a(9), 0, 0, "R7 rd");
    bus(1, 0, 22'd0, 0, 0, "R11 word0");
    bus(1, 1, 22'h400, 32'hffff_ffff, 0, "R11 pend wr");
    bus(1, 0, 22'h400, 0, 0, "R5 after wr");
    bus(1, 0, 22'h801, 0, 0, "R11 en gap");
    bus(1, 0, 22'h80002, 0, 0, "R11 cl gap");
    bus(1, 0, 22'h88001, 0, 0, "R11 past ctx");
    // random mix
    s = '0;
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 9);
      int n = $urandom_range(0, 31);
      logic [21:0] a;
      bit we = $urandom_range(0, 1) == 1;
      logic [31:0] wd = $urandom();
      if ($urandom_range(0, 3) == 0) s[$urandom_range(0, 31)] ^= 1'b1;
      case (sel)
        0: a = 22'h400;
        1, 2: a = en_a(n);
        3, 4, 5: a = cl_a(n);
        6: a = thr_a(n);
        7: a = 22'($urandom_range(0, 40));
        default: a = 22'($urandom());
      endcase
      if (sel >= 3 && sel <= 5 && we) wd = 32'($urandom_range(0, 34));
      bus($urandom_range(0, 4) != 0, we, a, wd, s, "R2 R8 R10 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule